// File: doc/BRIEF.md
# Translation Access-Rights Fault Unit

This unit sits beside the translation lookaside buffer. For every translated access it receives the outcome of the lookup: whether an entry matched, whether that entry is valid, which way it lives in, and its two protection bits. It also receives whether the access is a load or a store and whether it was issued in user or privileged mode. When a valid matching entry forbids the access, the unit performs the hardware half of exception entry in a single clock edge. It captures the page number and the full faulting address, and it records an event code that tells a load from a store. It saves the return PC, using the branch PC when the faulting instruction sat in a delay slot. It saves the old status word and produces the new one with privileged mode, exception blocking and the alternate register bank all turned on. It also notes which way faulted.

A one-cycle exception request leaves the unit on the same edge that commits these registers, and it starts the vector fetch. The status word fed back to the unit tells it when exceptions are blocked, and while they are blocked it accepts no new fault. If no fault occurs, every captured register keeps its value.

Top module: `tlb_prot_fault_unit`

## Requirements
- R1: A fault is raised only when `acc_req`, `tlb_hit` and `ent_valid` are all 1. A miss or an invalid entry never raises one, whatever the rights.
- R2: Rights encoding of `ent_prot`: 00 allows privileged reads only, 01 allows privileged reads and writes, 10 allows reads in either mode, 11 allows everything. A user access (`acc_priv`=0) to an encoding with bit 1 clear faults, and a store (`acc_store`=1) to an encoding with bit 0 clear faults.
- R3: On a fault, `entry_vpn` takes `fault_va[31:10]`.
- R4: On a fault, `fault_addr` takes all 32 bits of `fault_va`.
- R5: On a fault, `evt_code` takes 0x0A0 for a load and 0x0C0 for a store.
- R6: On a fault, `saved_pc` takes `cur_pc`, or `branch_pc` when `in_delay_slot` is 1.
- R7: On a fault, `saved_sr` takes the value of `sr_in` from the faulting cycle.
- R8: On a fault, `status_out` takes `sr_in` with bits 30 (mode), 29 (register bank) and 28 (block) forced to 1. All other bits are copied unchanged.
- R9: On a fault, `replace_way` takes `hit_way`.
- R10: While `sr_in` bit 28 is 1, no fault is accepted, and neither the outputs nor `exc_req` change.
- R11: Reset clears every output to 0. `exc_req` is high for exactly the cycle after the edge that commits a fault. All captured registers change on that same edge and hold their values in every cycle without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req | input | 1 | A translated access is presented this cycle |
| tlb_hit | input | 1 | The address matched an entry |
| ent_valid | input | 1 | Valid bit of the matched entry |
| hit_way | input | 2 | Way index of the matched entry |
| ent_prot | input | 2 | Access-rights field of the matched entry |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_priv | input | 1 | 1 = privileged access, 0 = user access |
| fault_va | input | 32 | Virtual address of the access |
| cur_pc | input | 32 | PC of the accessing instruction |
| in_delay_slot | input | 1 | Access issued from a delay slot |
| branch_pc | input | 32 | PC of the delayed branch owning the slot |
| sr_in | input | 32 | Current status word |
| exc_req | output | 1 | One-cycle exception request to the vector fetch |
| entry_vpn | output | 22 | Captured virtual page number |
| fault_addr | output | 32 | Captured faulting address |
| evt_code | output | 12 | Captured exception event code |
| saved_pc | output | 32 | Captured return PC |
| saved_sr | output | 32 | Captured old status word |
| status_out | output | 32 | New status word after entry |
| replace_way | output | 2 | Captured faulting way |

## Verification
Two functions can fall in the same cycle here. One is the acceptance of a fault. The other is the blocking rule that the status word applies to that same fault. The bench presents accesses that violate the rights while `sr_in` has its block bit set, and places them directly after committed faults, including a back-to-back pair where the second access is unblocked. The scoreboard model then decides, cycle by cycle, whether a fault must appear and which captured values must persist. A delay-slot fault that is also a store checks that the return-PC choice and the event-code choice combine correctly within one commit.

// File: rtl/tlbpv_pkg.sv
package tlbpv_pkg;

  localparam int PROT_W = 2;

  // Rights check: bit 1 grants user access, bit 0 grants writes.
  function automatic logic rights_ok(input logic [PROT_W-1:0] prot,
                                     input logic store,
                                     input logic priv);
    logic mode_ok;
    logic kind_ok;
    mode_ok = priv | prot[1];
    kind_ok = ~store | prot[0];
    return mode_ok & kind_ok;
  endfunction

  // Event code for a rights fault, by access kind.
  function automatic logic [11:0] fault_code(input logic store);
    return store ? 12'h0C0 : 12'h0A0;
  endfunction

endpackage

// File: rtl/tlbpv_rights.sv
module tlbpv_rights
  import tlbpv_pkg::*;
(
  input  logic              acc_req,
  input  logic              tlb_hit,
  input  logic              ent_valid,
  input  logic [PROT_W-1:0] ent_prot,
  input  logic              acc_store,
  input  logic              acc_priv,
  input  logic              blocked,
  output logic              rights_fail,
  output logic              viol_fire
);

  logic matched;

  always_comb begin
    matched     = acc_req & tlb_hit & ent_valid;
    rights_fail = matched & ~rights_ok(ent_prot, acc_store, acc_priv);
    viol_fire   = rights_fail & ~blocked;
  end

endmodule

// File: rtl/tlbpv_capture.sv
module tlbpv_capture
  import tlbpv_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int WAY_W      = 2,
  parameter int SR_W       = 32,
  parameter int MD_BIT     = 30,
  parameter int RB_BIT     = 29,
  parameter int BL_BIT     = 28,
  localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [VA_W-1:0]  va,
  input  logic [VA_W-1:0]  pc,
  input  logic             delay_slot,
  input  logic [VA_W-1:0]  br_pc,
  input  logic             store,
  input  logic [WAY_W-1:0] way,
  input  logic [SR_W-1:0]  sr_cur,
  output logic             req_q,
  output logic [VPN_W-1:0] vpn_q,
  output logic [VA_W-1:0]  addr_q,
  output logic [11:0]      code_q,
  output logic [VA_W-1:0]  spc_q,
  output logic [SR_W-1:0]  ssr_q,
  output logic [SR_W-1:0]  sr_q,
  output logic [WAY_W-1:0] way_q
);

  function automatic logic [SR_W-1:0] enter_sr(input logic [SR_W-1:0] s);
    logic [SR_W-1:0] r;
    r         = s;
    r[MD_BIT] = 1'b1;
    r[RB_BIT] = 1'b1;
    r[BL_BIT] = 1'b1;
    return r;
  endfunction

  logic [VA_W-1:0] ret_pc;

  always_comb ret_pc = delay_slot ? br_pc : pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      vpn_q  <= '0;
      addr_q <= '0;
      code_q <= '0;
      spc_q  <= '0;
      ssr_q  <= '0;
      sr_q   <= '0;
      way_q  <= '0;
    end else begin
      req_q <= fire;
      if (fire) begin
        vpn_q  <= va[VA_W-1:PAGE_SHIFT];
        addr_q <= va;
        code_q <= fault_code(store);
        spc_q  <= ret_pc;
        ssr_q  <= sr_cur;
        sr_q   <= enter_sr(sr_cur);
        way_q  <= way;
      end
    end
  end

endmodule

// File: rtl/tlb_prot_fault_unit.sv
module tlb_prot_fault_unit
  import tlbpv_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 10,
  parameter int WAY_W      = 2,
  parameter int SR_W       = 32,
  parameter int MD_BIT     = 30,
  parameter int RB_BIT     = 29,
  parameter int BL_BIT     = 28,
  localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic              tlb_hit,
  input  logic              ent_valid,
  input  logic [WAY_W-1:0]  hit_way,
  input  logic [PROT_W-1:0] ent_prot,
  input  logic              acc_store,
  input  logic              acc_priv,
  input  logic [VA_W-1:0]   fault_va,
  input  logic [VA_W-1:0]   cur_pc,
  input  logic              in_delay_slot,
  input  logic [VA_W-1:0]   branch_pc,
  input  logic [SR_W-1:0]   sr_in,
  output logic              exc_req,
  output logic [VPN_W-1:0]  entry_vpn,
  output logic [VA_W-1:0]   fault_addr,
  output logic [11:0]       evt_code,
  output logic [VA_W-1:0]   saved_pc,
  output logic [SR_W-1:0]   saved_sr,
  output logic [SR_W-1:0]   status_out,
  output logic [WAY_W-1:0]  replace_way
);

  logic rights_fail;
  logic viol_fire;
  logic blocked;

  always_comb blocked = sr_in[BL_BIT];

  tlbpv_rights u_rights (
    .acc_req    (acc_req),
    .tlb_hit    (tlb_hit),
    .ent_valid  (ent_valid),
    .ent_prot   (ent_prot),
    .acc_store  (acc_store),
    .acc_priv   (acc_priv),
    .blocked    (blocked),
    .rights_fail(rights_fail),
    .viol_fire  (viol_fire)
  );

  tlbpv_capture #(
    .VA_W      (VA_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .WAY_W     (WAY_W),
    .SR_W      (SR_W),
    .MD_BIT    (MD_BIT),
    .RB_BIT    (RB_BIT),
    .BL_BIT    (BL_BIT)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (viol_fire),
    .va        (fault_va),
    .pc        (cur_pc),
    .delay_slot(in_delay_slot),
    .br_pc     (branch_pc),
    .store     (acc_store),
    .way       (hit_way),
    .sr_cur    (sr_in),
    .req_q     (exc_req),
    .vpn_q     (entry_vpn),
    .addr_q    (fault_addr),
    .code_q    (evt_code),
    .spc_q     (saved_pc),
    .ssr_q     (saved_sr),
    .sr_q      (status_out),
    .way_q     (replace_way)
  );

endmodule

// File: rtl/tlbpv_checker.sv
module tlbpv_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_req,
  input logic        tlb_hit,
  input logic        ent_valid,
  input logic [1:0]  hit_way,
  input logic        acc_store,
  input logic [31:0] fault_va,
  input logic [31:0] sr_in,
  input logic        rights_fail,
  input logic        exc_req,
  input logic [21:0] entry_vpn,
  input logic [31:0] fault_addr,
  input logic [11:0] evt_code,
  input logic [31:0] saved_pc,
  input logic [31:0] saved_sr,
  input logic [31:0] status_out,
  input logic [1:0]  replace_way
);

  p_hit_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(acc_req && tlb_hit && ent_valid));

  p_rights_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(rights_fail));

  p_vpn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> entry_vpn == $past(fault_va[31:10]));

  p_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> fault_addr == $past(fault_va));

  p_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> evt_code == ($past(acc_store) ? 12'h0C0 : 12'h0A0));

  p_ssr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> saved_sr == $past(sr_in));

  p_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (status_out[30] && status_out[29] && status_out[28]));

  p_way_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> replace_way == $past(hit_way));

  p_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sr_in[28] |=> !exc_req);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> ($stable(fault_addr) && $stable(saved_pc) && $stable(saved_sr)
                  && $stable(status_out) && $stable(evt_code)
                  && $stable(replace_way) && $stable(entry_vpn)));

endmodule

bind tlb_prot_fault_unit tlbpv_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_req    (acc_req),
  .tlb_hit    (tlb_hit),
  .ent_valid  (ent_valid),
  .hit_way    (hit_way),
  .acc_store  (acc_store),
  .fault_va   (fault_va),
  .sr_in      (sr_in),
  .rights_fail(rights_fail),
  .exc_req    (exc_req),
  .entry_vpn  (entry_vpn),
  .fault_addr (fault_addr),
  .evt_code   (evt_code),
  .saved_pc   (saved_pc),
  .saved_sr   (saved_sr),
  .status_out (status_out),
  .replace_way(replace_way)
);

// File: tb/sim_tlb_prot_fault_unit.sv
module sim_tlb_prot_fault_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_req = 1'b0, tlb_hit = 1'b0, ent_valid = 1'b0;
  logic [1:0]  hit_way = '0, ent_prot = '0;
  logic        acc_store = 1'b0, acc_priv = 1'b0, in_delay_slot = 1'b0;
  logic [31:0] fault_va = '0, cur_pc = '0, branch_pc = '0, sr_in = '0;
  logic        exc_req;
  logic [21:0] entry_vpn;
  logic [31:0] fault_addr, saved_pc, saved_sr, status_out;
  logic [11:0] evt_code;
  logic [1:0]  replace_way;

  always #4 clk = ~clk;

  tlb_prot_fault_unit u0 (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .tlb_hit(tlb_hit),
    .ent_valid(ent_valid), .hit_way(hit_way), .ent_prot(ent_prot),
    .acc_store(acc_store), .acc_priv(acc_priv), .fault_va(fault_va),
    .cur_pc(cur_pc), .in_delay_slot(in_delay_slot), .branch_pc(branch_pc),
    .sr_in(sr_in), .exc_req(exc_req), .entry_vpn(entry_vpn),
    .fault_addr(fault_addr), .evt_code(evt_code), .saved_pc(saved_pc),
    .saved_sr(saved_sr), .status_out(status_out), .replace_way(replace_way)
  );

  typedef struct {
    logic        exc;
    logic [21:0] vpn;
    logic [31:0] fa;
    logic [11:0] code;
    logic [31:0] spc;
    logic [31:0] ssr;
    logic [31:0] sr;
    logic [1:0]  way;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t mdl;
  int checks = 0;
  int errors = 0;

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic compare(input exp_t e);
    checks++;
    if (exc_req !== e.exc || entry_vpn !== e.vpn || fault_addr !== e.fa ||
        evt_code !== e.code || saved_pc !== e.spc || saved_sr !== e.ssr ||
        status_out !== e.sr || replace_way !== e.way) begin
      errors++;
      $display("FAIL %s: actual exc=%0b vpn=%h fa=%h code=%h spc=%h ssr=%h sr=%h way=%0d expected exc=%0b vpn=%h fa=%h code=%h spc=%h ssr=%h sr=%h way=%0d",
               e.tag, exc_req, entry_vpn, fault_addr, evt_code, saved_pc, saved_sr,
               status_out, replace_way, e.exc, e.vpn, e.fa, e.code, e.spc, e.ssr,
               e.sr, e.way);
    end
  endtask

  // Driver: one access per cycle, expected result pushed to the scoreboard.
  task automatic drive(input bit req, input bit hit, input bit v,
                       input bit [1:0] way, input bit [1:0] prot,
                       input bit st, input bit pr, input bit [31:0] va,
                       input bit [31:0] pc, input bit ds, input bit [31:0] bpc,
                       input bit [31:0] sr, input string tag);
    bit allowed;
    bit fire;
    @(negedge clk);
    acc_req = req; tlb_hit = hit; ent_valid = v; hit_way = way;
    ent_prot = prot; acc_store = st; acc_priv = pr; fault_va = va;
    cur_pc = pc; in_delay_slot = ds; branch_pc = bpc; sr_in = sr;
    allowed = !((!pr && prot < 2'd2) || (st && (prot == 2'd0 || prot == 2'd2)));
    fire = req && hit && v && !allowed && !sr[28];
    mdl.exc = fire;
    if (fire) begin
      mdl.vpn  = va >> 10;
      mdl.fa   = va;
      mdl.code = st ? 12'd192 : 12'd160;
      mdl.spc  = ds ? bpc : pc;
      mdl.ssr  = sr;
      mdl.sr   = sr | 32'h7000_0000;
      mdl.way  = way;
    end
    mdl.tag = tag;
    q.push_back(mdl);
  endtask

  // Monitor: pops one item per driven cycle, shortly after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    mdl = '{exc: 1'b0, vpn: '0, fa: '0, code: '0, spc: '0, ssr: '0, sr: '0,
            way: '0, tag: "R11 reset"};
    repeat (3) @(negedge clk);
    compare(mdl);
    rst_n = 1'b1;

    // R1: miss or invalid entry never faults, even with forbidden rights
    drive(1, 0, 1, 2'd1, 2'b00, 1, 0, 32'h1234_5678, 32'h100, 0, 0, 32'h0, "R1 miss");
    drive(1, 1, 0, 2'd2, 2'b00, 1, 0, 32'h1234_5678, 32'h104, 0, 0, 32'h0, "R1 invalid");
    drive(0, 1, 1, 2'd3, 2'b00, 1, 0, 32'h1234_5678, 32'h108, 0, 0, 32'h0, "R1 no access");

    // R2..R9: every rights code against every access kind
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) begin
        drive(1, 1, 1, 2'(p + k), 2'(p), k[0], k[1],
              32'hA000_0000 + 32'(p * 4096 + k * 1027), 32'h8000_0000 + 32'(p * 16 + k),
              0, 32'hDEAD_0000, 32'h0000_00F0 + 32'(k), "R2 R3 R4 R5 R9 rights sweep");
      end
    end

    // R6: delay slot uses the branch PC; store code combines in same commit
    drive(1, 1, 1, 2'd2, 2'b10, 1, 1, 32'hFFFF_FC01, 32'h0C00_0010, 1, 32'h0C00_000C,
          32'h0000_0003, "R6 R5 delay-slot store");
    drive(1, 1, 1, 2'd1, 2'b01, 0, 0, 32'h0040_0400, 32'h0C00_0020, 0, 32'h0C00_0AAA,
          32'h8000_0001, "R6 R7 R8 no slot load");
    // R10: blocked by status word, registers hold
    drive(1, 1, 1, 2'd3, 2'b00, 1, 0, 32'h5555_5555, 32'h0C00_0030, 0, 0,
          32'h1000_0000, "R10 blocked");
    drive(1, 1, 1, 2'd0, 2'b10, 1, 0, 32'h6666_6666, 32'h0C00_0034, 1, 32'h77,
          32'hF000_0000, "R10 blocked all bits");
    // R11: back-to-back faults, then idle hold
    drive(1, 1, 1, 2'd0, 2'b00, 0, 0, 32'h0000_0400, 32'h0C00_0040, 0, 0, 32'h0,
          "R11 first of pair");
    drive(1, 1, 1, 2'd3, 2'b10, 1, 1, 32'h0000_0800, 32'h0C00_0044, 0, 0, 32'h0000_0100,
          "R11 second of pair");
    drive(0, 0, 0, 2'd1, 2'b11, 0, 1, 32'h9999_9999, 32'h0, 0, 0, 32'h0, "R11 idle hold");
    drive(1, 1, 1, 2'd2, 2'b11, 1, 0, 32'h9999_9999, 32'h0, 0, 0, 32'h0, "R2 R11 allowed hold");

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R11 scoreboard drain: actual=%0d expected=0", q.size());
    end
    summary();
    $finish;
  end

endmodule